// File: doc/BRIEF.md
# Transmit Frame Control Engine

This block sits between a transmit packet FIFO and an Ethernet-style MAC. It watches how much of the current packet is held in the FIFO and, once enough has arrived or the whole packet is present, it asks the MAC to begin a frame. It then moves the packet to the MAC one word per cycle. It owns the FIFO read address and keeps the address where the packet starts, so it can go back to that point and send the frame again.

The MAC can ask for a retry after a normal collision, or report a fatal error. After a retry the frame is sent again from its start. After an error the rest of the packet is drained from the FIFO without being sent. If the FIFO runs dry in the middle of a frame (an underrun), the packet is sent again from its start, at most three times, and only while its first word is still in the FIFO. If it cannot be sent again, the packet is dropped. The packet's producer index then goes out on a completion port so that the host can be told. While a frame is in flight and the packet is also the one the DMA is filling, low FIFO occupancy raises a priority request toward the bus arbiter. A sleep input returns every state machine to idle.

Top module: `txf_engine`

## Requirements
- R1: A frame starts only when the FIFO level is non-zero and either strictly greater than `txThreshold` or `fifoEopInFifo` is high. A level equal to the threshold, with no end of packet present, does not start a frame. The start appears as a one-cycle `macStart` pulse in the cycle after the edge that sees the condition.
- R2: While a frame is being sent and the FIFO level is non-zero, each clock edge reads the word at `fifoRdAddr`. That word appears in the next cycle on `macData`, with `macValid` high and `macLast` equal to `fifoRdLast`. The read address steps by one. The frame ends after the word marked last.
- R3: During and straight after reset, `macStart`, `macValid`, `macLast`, `cmplValid` and `dmaHighPri` are low and `fifoRdAddr` is 0.
- R4: A `macRetry` seen while a frame is being sent moves the read address back to the start of the packet. The whole packet is then sent again, after a new `macStart`.
- R5: A `macError` seen while a frame is being sent stops the frame. No further word reaches the MAC, and no completion is produced. The remaining words of the packet, up to and including the last one, are read and thrown away. The next packet is then sent normally.
- R6: An underrun is a FIFO level of zero in the middle of a frame. When the start of the packet is not overwritten and fewer than three retransmissions have been made, an underrun moves the read address back to the start of the packet and the frame is started again.
- R7: An underrun that occurs after three retransmissions of the same packet drops it. A packet therefore gets at most four `macStart` pulses from underruns.
- R8: Dropping a packet after an underrun produces a one-cycle `cmplValid` pulse, with `cmplIdx` equal to the `pktProdIdx` taken when the frame started. The remaining words of the packet are then discarded, and none of them reaches the MAC.
- R9: When `sopOverwritten` is high at an underrun, the packet is dropped at once, with no retransmission.
- R10: While `sleepReq` is high, the engine stays idle and drives no `macStart`, `macValid` or `dmaHighPri`. A frame in progress is moved back to its start and is sent in full once sleep is released.
- R11: `dmaHighPri` is high in the cycle after an edge at which all of these hold: a frame is being sent, `dmaSamePacket` is high, and the FIFO level is below `hpThreshold`. Otherwise it is low, which also covers the end of the packet.
- R12: The underrun retransmission count is cleared when a packet finishes or is dropped, so the next packet again gets three retransmissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sleepReq | input | 1 | Forces all state machines to idle while high |
| txThreshold | input | ADDR_W+1 | Start threshold on the FIFO level |
| hpThreshold | input | ADDR_W+1 | Level below which DMA priority is raised |
| fifoLevel | input | ADDR_W+1 | Number of packet words held beyond the read address |
| fifoEopInFifo | input | 1 | Last word of the current packet is in the FIFO |
| fifoRdData | input | DATA_W | FIFO word at `fifoRdAddr` |
| fifoRdLast | input | 1 | FIFO word at `fifoRdAddr` is the last word of a packet |
| fifoRdAddr | output | ADDR_W | FIFO read address |
| sopOverwritten | input | 1 | First word of the current packet has been overwritten |
| dmaSamePacket | input | 1 | DMA is filling the packet now being sent |
| pktProdIdx | input | IDX_W | Producer index of the packet at the FIFO head |
| macRetry | input | 1 | MAC asks for the frame to be sent again (normal collision) |
| macError | input | 1 | MAC reports a fatal transmit error |
| macStart | output | 1 | One-cycle frame start request |
| macValid | output | 1 | `macData` holds a frame word |
| macData | output | DATA_W | Frame data word |
| macLast | output | 1 | Current word is the last one of the frame |
| dmaHighPri | output | 1 | Priority-boost request toward the arbiter |
| cmplValid | output | 1 | One-cycle pulse: packet dropped after an underrun |
| cmplIdx | output | IDX_W | Producer index of the dropped packet |

## Verification
The bench checks the start threshold at its exact boundary: a design that starts on an equal level would begin a frame with only four of five words present. It checks the underrun limit by counting frame starts. A counter that is off by one shows five starts or three, and a counter that is not cleared leaves the second dropped packet with fewer starts. Retry, sleep and underrun recovery are checked by comparing the words sent after the last start with the whole packet. A read address that is not moved back shows up as a missing or repeated word. After an error or a drop, the bench checks that the discarded words never reach the MAC and that the read address still reaches the end of the packet. The boost test counts the exact number of high cycles, and checks that none occur when the DMA is working on a different packet.

// File: rtl/txf_pkg.sv
package txf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_FLUSH = 2'd2
  } txState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic saveSop;    // capture start-of-packet address and index
    logic rewind;     // read address back to start of packet
    logic advance;    // read address forward by one
    logic emitWord;   // present the current FIFO word to the MAC
    logic emitStart;  // pulse frame start to the MAC
    logic emitCmpl;   // pulse completion for a dropped packet
  } txStrobe_t;

endpackage

// File: rtl/txf_control.sv
module txf_control
  import txf_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int MAX_UR_RETRY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleepReq,
  input  logic [ADDR_W:0]   txThreshold,
  input  logic [ADDR_W:0]   hpThreshold,
  input  logic [ADDR_W:0]   fifoLevel,
  input  logic              fifoEopInFifo,
  input  logic              fifoRdLast,
  input  logic              sopOverwritten,
  input  logic              dmaSamePacket,
  input  logic              macRetry,
  input  logic              macError,
  output txStrobe_t         strb,
  output txState_e          state,
  output logic              dmaHighPri
);

  localparam int RTRY_W = $clog2(MAX_UR_RETRY + 1);
  localparam logic [RTRY_W-1:0] RTRY_LIMIT = RTRY_W'(MAX_UR_RETRY);

  txState_e          nextState;
  logic [RTRY_W-1:0] urCnt;
  logic [RTRY_W-1:0] urNext;
  logic              haveWord;
  logic              startOk;
  logic              giveUp;
  logic              boostNext;

  assign haveWord = (fifoLevel != '0);
  assign startOk  = haveWord && ((fifoLevel > txThreshold) || fifoEopInFifo);
  assign giveUp   = sopOverwritten || (urCnt == RTRY_LIMIT);

  always_comb begin
    strb      = '0;
    nextState = state;
    urNext    = urCnt;
    if (sleepReq) begin
      nextState   = ST_IDLE;
      urNext      = '0;
      strb.rewind = (state != ST_IDLE);
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startOk) begin
            strb.saveSop   = 1'b1;
            strb.emitStart = 1'b1;
            nextState      = ST_SEND;
          end
        end
        ST_SEND: begin
          if (macError) begin
            nextState = ST_FLUSH;
            urNext    = '0;
          end else if (macRetry) begin
            strb.rewind = 1'b1;
            nextState   = ST_IDLE;
          end else if (!haveWord) begin
            if (giveUp) begin
              strb.emitCmpl = 1'b1;
              nextState     = ST_FLUSH;
              urNext        = '0;
            end else begin
              strb.rewind = 1'b1;
              urNext      = urCnt + 1'b1;
              nextState   = ST_IDLE;
            end
          end else begin
            strb.advance  = 1'b1;
            strb.emitWord = 1'b1;
            if (fifoRdLast) begin
              nextState = ST_IDLE;
              urNext    = '0;
            end
          end
        end
        ST_FLUSH: begin
          if (haveWord) begin
            strb.advance = 1'b1;
            if (fifoRdLast) nextState = ST_IDLE;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  assign boostNext = !sleepReq && (state == ST_SEND) && dmaSamePacket &&
                     (fifoLevel < hpThreshold);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      urCnt      <= '0;
      dmaHighPri <= 1'b0;
    end else begin
      state      <= nextState;
      urCnt      <= urNext;
      dmaHighPri <= boostNext;
    end
  end

endmodule

// File: rtl/txf_datapath.sv
module txf_datapath
  import txf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic [DATA_W-1:0] fifoRdData,
  input  logic              fifoRdLast,
  input  logic [IDX_W-1:0]  pktProdIdx,
  output logic [ADDR_W-1:0] fifoRdAddr,
  output logic              macStart,
  output logic              macValid,
  output logic [DATA_W-1:0] macData,
  output logic              macLast,
  output logic              cmplValid,
  output logic [IDX_W-1:0]  cmplIdx
);

  logic [ADDR_W-1:0] sopAddr;
  logic [IDX_W-1:0]  sopIdx;

  // Read address with start-of-packet bookmark
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoRdAddr <= '0;
      sopAddr    <= '0;
      sopIdx     <= '0;
    end else begin
      if (strb.saveSop) begin
        sopAddr <= fifoRdAddr;
        sopIdx  <= pktProdIdx;
      end
      if (strb.rewind)       fifoRdAddr <= sopAddr;
      else if (strb.advance) fifoRdAddr <= fifoRdAddr + 1'b1;
    end
  end

  // MAC-facing registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      macStart <= 1'b0;
      macValid <= 1'b0;
      macData  <= '0;
      macLast  <= 1'b0;
    end else begin
      macStart <= strb.emitStart;
      macValid <= strb.emitWord;
      macLast  <= strb.emitWord && fifoRdLast;
      if (strb.emitWord) macData <= fifoRdData;
    end
  end

  // Completion for a dropped packet
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmplValid <= 1'b0;
      cmplIdx   <= '0;
    end else begin
      cmplValid <= strb.emitCmpl;
      if (strb.emitCmpl) cmplIdx <= sopIdx;
    end
  end

endmodule

// File: rtl/txf_engine.sv
module txf_engine
  import txf_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 6,
  parameter int IDX_W        = 8,
  parameter int MAX_UR_RETRY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleepReq,
  input  logic [ADDR_W:0]   txThreshold,
  input  logic [ADDR_W:0]   hpThreshold,
  input  logic [ADDR_W:0]   fifoLevel,
  input  logic              fifoEopInFifo,
  input  logic [DATA_W-1:0] fifoRdData,
  input  logic              fifoRdLast,
  output logic [ADDR_W-1:0] fifoRdAddr,
  input  logic              sopOverwritten,
  input  logic              dmaSamePacket,
  input  logic [IDX_W-1:0]  pktProdIdx,
  input  logic              macRetry,
  input  logic              macError,
  output logic              macStart,
  output logic              macValid,
  output logic [DATA_W-1:0] macData,
  output logic              macLast,
  output logic              dmaHighPri,
  output logic              cmplValid,
  output logic [IDX_W-1:0]  cmplIdx
);

  txStrobe_t strb;
  txState_e  ctrlState;

  txf_control #(
    .ADDR_W      (ADDR_W),
    .MAX_UR_RETRY(MAX_UR_RETRY)
  ) ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .sleepReq      (sleepReq),
    .txThreshold   (txThreshold),
    .hpThreshold   (hpThreshold),
    .fifoLevel     (fifoLevel),
    .fifoEopInFifo (fifoEopInFifo),
    .fifoRdLast    (fifoRdLast),
    .sopOverwritten(sopOverwritten),
    .dmaSamePacket (dmaSamePacket),
    .macRetry      (macRetry),
    .macError      (macError),
    .strb          (strb),
    .state         (ctrlState),
    .dmaHighPri    (dmaHighPri)
  );

  txf_datapath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .fifoRdData(fifoRdData),
    .fifoRdLast(fifoRdLast),
    .pktProdIdx(pktProdIdx),
    .fifoRdAddr(fifoRdAddr),
    .macStart  (macStart),
    .macValid  (macValid),
    .macData   (macData),
    .macLast   (macLast),
    .cmplValid (cmplValid),
    .cmplIdx   (cmplIdx)
  );

endmodule

// File: rtl/txf_engine_chk.sv
module txf_engine_chk
  import txf_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              sleepReq,
  input logic [ADDR_W:0]   txThreshold,
  input logic [ADDR_W:0]   hpThreshold,
  input logic [ADDR_W:0]   fifoLevel,
  input logic              fifoEopInFifo,
  input logic              dmaSamePacket,
  input logic              macError,
  input logic              macStart,
  input logic              macValid,
  input logic              dmaHighPri,
  input logic              cmplValid,
  input logic [ADDR_W-1:0] fifoRdAddr,
  input logic              strbAdvance,
  input logic              strbRewind,
  input txState_e          state
);

  a_r1_start_needs_cond: assert property (@(posedge clk) disable iff (!rstN)
    macStart |-> $past(fifoLevel != '0 && !sleepReq &&
                       (fifoLevel > txThreshold || fifoEopInFifo)));

  a_r2_addr_steps_one: assert property (@(posedge clk) disable iff (!rstN)
    strbAdvance |=> fifoRdAddr == ADDR_W'($past(fifoRdAddr) + 1'b1));

  a_r4_rewind_no_word: assert property (@(posedge clk) disable iff (!rstN)
    strbRewind |=> !macValid);

  a_r5_error_stops: assert property (@(posedge clk) disable iff (!rstN)
    (macError && state == ST_SEND) |=> !macValid);

  a_r8_cmpl_on_underrun: assert property (@(posedge clk) disable iff (!rstN)
    cmplValid |-> $past(state == ST_SEND && fifoLevel == '0));

  a_r10_sleep_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $past(sleepReq) |-> (!macStart && !macValid && !dmaHighPri));

  a_r11_boost_cause: assert property (@(posedge clk) disable iff (!rstN)
    dmaHighPri |-> $past(state == ST_SEND && dmaSamePacket &&
                         fifoLevel < hpThreshold));

endmodule

bind txf_engine txf_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .sleepReq     (sleepReq),
  .txThreshold  (txThreshold),
  .hpThreshold  (hpThreshold),
  .fifoLevel    (fifoLevel),
  .fifoEopInFifo(fifoEopInFifo),
  .dmaSamePacket(dmaSamePacket),
  .macError     (macError),
  .macStart     (macStart),
  .macValid     (macValid),
  .dmaHighPri   (dmaHighPri),
  .cmplValid    (cmplValid),
  .fifoRdAddr   (fifoRdAddr),
  .strbAdvance  (strb.advance),
  .strbRewind   (strb.rewind),
  .state        (ctrlState)
);

// File: tb/txf_engine_tb_top.sv
module txf_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sleepReq = 1'b0;
  logic [AW:0]   txThreshold = '0;
  logic [AW:0]   hpThreshold = '0;
  logic [AW:0]   fifoLevel;
  logic          fifoEopInFifo = 1'b0;
  logic [DW-1:0] fifoRdData;
  logic          fifoRdLast;
  logic [AW-1:0] fifoRdAddr;
  logic          sopOverwritten = 1'b0;
  logic          dmaSamePacket = 1'b0;
  logic [IW-1:0] pktProdIdx = '0;
  logic          macRetry = 1'b0;
  logic          macError = 1'b0;
  logic          macStart, macValid, macLast, dmaHighPri, cmplValid;
  logic [DW-1:0] macData;
  logic [IW-1:0] cmplIdx;

  always #(CLK_PERIOD/2) clk = ~clk;

  txf_engine #(.DATA_W(DW), .ADDR_W(AW), .IDX_W(IW), .MAX_UR_RETRY(3)) dut_i (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq),
    .txThreshold(txThreshold), .hpThreshold(hpThreshold),
    .fifoLevel(fifoLevel), .fifoEopInFifo(fifoEopInFifo),
    .fifoRdData(fifoRdData), .fifoRdLast(fifoRdLast), .fifoRdAddr(fifoRdAddr),
    .sopOverwritten(sopOverwritten), .dmaSamePacket(dmaSamePacket),
    .pktProdIdx(pktProdIdx), .macRetry(macRetry), .macError(macError),
    .macStart(macStart), .macValid(macValid), .macData(macData),
    .macLast(macLast), .dmaHighPri(dmaHighPri),
    .cmplValid(cmplValid), .cmplIdx(cmplIdx)
  );

  // FIFO model
  logic [DW-1:0] mem [0:255];
  logic          lastMem [0:255];
  int            wrCnt = 0;
  assign fifoLevel  = (AW+1)'(wrCnt) - {1'b0, fifoRdAddr};
  assign fifoRdData = mem[fifoRdAddr];
  assign fifoRdLast = lastMem[fifoRdAddr];

  // Output monitor
  int          startCnt = 0, rxCnt = 0, rxAtStart = 0, cmplCnt = 0, boostCnt = 0;
  logic [DW-1:0] rxData [0:511];
  logic          rxLast [0:511];
  logic [IW-1:0] cmplSeen = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (macStart) begin startCnt++; rxAtStart = rxCnt; end
      if (macValid && rxCnt < 512) begin
        rxData[rxCnt] = macData; rxLast[rxCnt] = macLast; rxCnt++;
      end
      if (cmplValid) begin cmplCnt++; cmplSeen = cmplIdx; end
      if (dmaHighPri) boostCnt++;
    end
  end

  int checks = 0, failures = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic newPkt(); fifoEopInFifo = 1'b0; endtask

  task automatic push(input logic [DW-1:0] base, input int first, input int n,
                      input bit withEop, input int total);
    for (int i = 0; i < n; i++) begin
      mem[wrCnt]     = base + DW'(first + i);
      lastMem[wrCnt] = withEop && (first + i == total - 1);
      wrCnt++;
    end
    if (withEop) fifoEopInFifo = 1'b1;
  endtask

  task automatic waitDrained();
    for (int i = 0; i < 300 && (int'(fifoRdAddr) != wrCnt); i++) tick();
    repeat (3) tick();
  endtask

  task automatic waitRx(input int target);
    for (int i = 0; i < 300 && rxCnt < target; i++) tick();
  endtask

  task automatic checkPkt(input string req, input int from,
                          input logic [DW-1:0] base, input int n);
    check(rxCnt - from == n, req, "frame word count", rxCnt - from, n);
    for (int i = 0; i < n; i++) begin
      check(rxData[from+i] == base + DW'(i), req, "frame word",
            rxData[from+i], base + DW'(i));
      check(rxLast[from+i] == (i == n-1), req, "last flag",
            rxLast[from+i], (i == n-1));
    end
  endtask

  task automatic t_reset();
    check(!macStart && !macValid && !macLast, "R3", "mac outputs after reset",
          {macStart, macValid, macLast}, 0);
    check(!cmplValid && !dmaHighPri, "R3", "cmpl/boost after reset",
          {cmplValid, dmaHighPri}, 0);
    check(fifoRdAddr == 0, "R3", "read address after reset", fifoRdAddr, 0);
  endtask

  task automatic t_threshold();
    int s;
    s = startCnt;
    txThreshold = 4; newPkt();
    push(32'h100, 0, 4, 0, 8);
    repeat (10) tick();
    check(startCnt == s, "R1", "no start at level equal to threshold", startCnt - s, 0);
    push(32'h100, 4, 1, 0, 8);
    tick();
    check(startCnt == s + 1, "R1", "start once level exceeds threshold", startCnt - s, 1);
    push(32'h100, 5, 3, 1, 8);
    waitDrained();
    checkPkt("R2", rxAtStart, 32'h100, 8);
  endtask

  task automatic t_eopStart();
    int s;
    s = startCnt;
    txThreshold = 20; newPkt();
    push(32'h200, 0, 2, 1, 2);
    waitDrained();
    check(startCnt == s + 1, "R1", "start on end of packet present", startCnt - s, 1);
    checkPkt("R2", rxAtStart, 32'h200, 2);
  endtask

  task automatic t_retry();
    int s, r;
    s = startCnt; r = rxCnt;
    txThreshold = 0; newPkt();
    push(32'h300, 0, 4, 1, 4);
    waitRx(r + 2);
    macRetry = 1'b1; tick(); macRetry = 1'b0;
    waitDrained();
    check(startCnt == s + 2, "R4", "restart after retry", startCnt - s, 2);
    checkPkt("R4", rxAtStart, 32'h300, 4);
  endtask

  task automatic t_error();
    int r, c, rAfter;
    r = rxCnt; c = cmplCnt;
    txThreshold = 0; newPkt();
    push(32'h400, 0, 6, 1, 6);
    waitRx(r + 2);
    macError = 1'b1; tick(); macError = 1'b0;
    rAfter = rxCnt;
    waitDrained();
    check(rxCnt == rAfter, "R5", "no words after error", rxCnt - rAfter, 0);
    check(int'(fifoRdAddr) == wrCnt, "R5", "rest of packet drained", fifoRdAddr, wrCnt);
    check(cmplCnt == c, "R5", "no completion on MAC error", cmplCnt - c, 0);
    newPkt();
    push(32'h480, 0, 1, 1, 1);
    waitDrained();
    checkPkt("R5", rxAtStart, 32'h480, 1);
  endtask

  task automatic t_urRecover();
    int s, c;
    s = startCnt; c = cmplCnt;
    txThreshold = 1; newPkt();
    push(32'h500, 0, 3, 0, 5);
    for (int i = 0; i < 100 && startCnt < s + 2; i++) tick();
    push(32'h500, 3, 2, 1, 5);
    waitDrained();
    check(startCnt >= s + 2 && startCnt <= s + 4, "R6", "retransmit after underrun",
          startCnt - s, 2);
    check(cmplCnt == c, "R6", "no completion when recovered", cmplCnt - c, 0);
    checkPkt("R6", rxAtStart, 32'h500, 5);
  endtask

  task automatic urAbort(input string req, input logic [DW-1:0] base,
                         input logic [IW-1:0] idx);
    int s, c, rHold;
    s = startCnt; c = cmplCnt;
    txThreshold = 1; pktProdIdx = idx; newPkt();
    push(base, 0, 2, 0, 5);
    repeat (60) tick();
    check(startCnt == s + 4, req, "starts before underrun drop", startCnt - s, 4);
    check(cmplCnt == c + 1, "R8", "one completion on drop", cmplCnt - c, 1);
    check(cmplSeen == idx, "R8", "completion producer index", cmplSeen, idx);
    rHold = rxCnt;
    push(base, 2, 3, 1, 5);
    waitDrained();
    check(rxCnt == rHold, "R8", "dropped packet words discarded", rxCnt - rHold, 0);
    check(int'(fifoRdAddr) == wrCnt, "R8", "dropped packet drained", fifoRdAddr, wrCnt);
  endtask

  task automatic t_sopOver();
    int s, c;
    s = startCnt; c = cmplCnt;
    txThreshold = 1; pktProdIdx = 8'h42; sopOverwritten = 1'b1; newPkt();
    push(32'h800, 0, 2, 0, 4);
    repeat (30) tick();
    check(startCnt == s + 1, "R9", "no retransmit when start overwritten", startCnt - s, 1);
    check(cmplCnt == c + 1, "R9", "completion on overwritten start", cmplCnt - c, 1);
    check(cmplSeen == 8'h42, "R9", "completion index", cmplSeen, 8'h42);
    sopOverwritten = 1'b0;
    push(32'h800, 2, 2, 1, 4);
    waitDrained();
  endtask

  task automatic t_boost();
    int b;
    txThreshold = 0; hpThreshold = 3; dmaSamePacket = 1'b1;
    b = boostCnt; newPkt();
    push(32'h900, 0, 6, 1, 6);
    waitDrained();
    check(boostCnt - b == 2, "R11", "boost cycles on shared packet", boostCnt - b, 2);
    check(!dmaHighPri, "R11", "boost low after packet end", dmaHighPri, 0);
    dmaSamePacket = 1'b0;
    b = boostCnt; newPkt();
    push(32'h980, 0, 6, 1, 6);
    waitDrained();
    check(boostCnt == b, "R11", "no boost on different packet", boostCnt - b, 0);
    checkPkt("R11", rxAtStart, 32'h980, 6);
  endtask

  task automatic t_sleep();
    int s, r, q;
    s = startCnt; r = rxCnt; q = 0;
    txThreshold = 0; newPkt();
    push(32'hA00, 0, 6, 1, 6);
    waitRx(r + 2);
    sleepReq = 1'b1; tick();
    r = rxCnt;
    for (int i = 0; i < 4; i++) begin
      tick();
      if (macValid || macStart) q++;
    end
    check(rxCnt == r && q == 0, "R10", "MAC quiet during sleep", rxCnt - r + q, 0);
    sleepReq = 1'b0;
    waitDrained();
    check(startCnt == s + 2, "R10", "frame restarted after sleep", startCnt - s, 2);
    checkPkt("R10", rxAtStart, 32'hA00, 6);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; lastMem[i] = 1'b0; end
    repeat (4) tick();
    t_reset();
    rstN = 1'b1;
    tick();
    t_reset();
    t_threshold();
    t_eopStart();
    t_retry();
    t_error();
    t_urRecover();
    urAbort("R7", 32'h600, 8'h5A);
    urAbort("R12", 32'h700, 8'h33);
    t_sopOver();
    t_boost();
    t_sleep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule